// File: doc/BRIEF.md
# Dual-Address DMA Channel

This block is one DMA channel that copies data between two addresses. Each unit goes through two bus accesses. A read at the source address is latched into a holding register. A later write stores that register at the destination address. Units can be 8, 16 or 32 bits wide. Either a software register write or a rising edge on a hardware request pin starts a run. Three trigger modes set how much one trigger moves:

- **Single** moves one unit per trigger.
- **Successive** moves the whole programmed count per trigger.
- **Block** moves one block of a programmed size per trigger.

Each address can independently stay fixed, count up or count down by the unit size. In successive and block modes, either address can be put back to its programmed start when the run ends.

Software programs the channel through a small register port and then starts it. The memory side is a request/ready bus with byte enables and little-endian byte lanes. The channel drives two active-low strobes. One pulses when a trigger is accepted. The other is held during the final write of each run.

Top module: `dma_dual_chan`

Register word addresses on `cfg_addr_i`:

| Address | Write | Read |
|---|---|---|
| 0 | Source start address | Current source address |
| 1 | Destination start address | Current destination address |
| 2 | Count | Remaining count |
| 3 | Block size | Block size |
| 4 | Control word | Control word |
| 5 | Bit 0 is the software trigger | Status {pending, done, busy} in bits [2:0] |

Control word fields:

| Bits | Field | Encoding |
|---|---|---|
| [1:0] | Unit size | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| [3:2] | Mode | 0 = single, 1 = successive, 2 = block |
| [5:4] | Source direction | 0 = fixed, 1 = up, 2 = down |
| [7:6] | Destination direction | 0 = fixed, 1 = up, 2 = down |
| 8 | Source restore enable | |
| 9 | Destination restore enable | |
| 10 | Hardware trigger enable | |

## Requirements
- R1: Each unit is a bus read at the current source address followed by a bus write at the current destination address. The write carries the bytes returned by the read, moved from the source byte lane (source address bits [1:0]) to the destination byte lane (destination address bits [1:0]).
- R2: The unit size code in control bits [1:0] selects the width: 0 is 8-bit, 1 is 16-bit and 2 is 32-bit. Byte enables are 1, 2 or 4 lanes starting at the lane of the aligned address, and an address step is 1, 2 or 4 bytes.
- R3: In single mode (control bits [3:2] = 0), each accepted trigger moves one unit and lowers the count by one.
- R4: In successive mode (control bits [3:2] = 1), one accepted trigger moves as many units as the count holds, and the count reaches zero.
- R5: In block mode (control bits [3:2] = 2), each accepted trigger moves block-size units and lowers the count by one per block.
- R6: After each unit, the direction code steps each address: 0 leaves it fixed, 1 adds the unit size and 2 subtracts it. Source direction is control bits [5:4] and destination direction is control bits [7:6].
- R7: In successive or block mode, when a run ends, control bit 8 restores the source address to its programmed start and bit 9 does the same for the destination address. Single mode never restores either address.
- R8: `ack_no` is low for exactly one cycle per accepted trigger. That cycle is the first cycle of the run's first read.
- R9: `end_no` is low during the final write of each run and at no other time. Exactly one write per run completes with it low.
- R10: A trigger that arrives while a run is active is held in a single pending slot. The held trigger is serviced after the run. Further triggers during the same run are merged into that slot.
- R11: A trigger accepted while the count is zero is dropped with no bus access. Status done (bit 1) sets when the count reaches zero, and a count write clears it.
- R12: With control bit 10 set, a rising edge on `hw_req_i` acts as one trigger. With bit 10 clear, the pin is ignored.
- R13: While a run is active, register writes other than the trigger register are ignored.
- R14: A bus request keeps its address, direction and byte enables steady until the cycle in which `bus_rdy_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for `cfg_addr_i` |
| hw_req_i | input | 1 | Hardware trigger request, rising edge |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 = write phase, 0 = read phase |
| bus_addr_o | output | AW | Byte address of the access |
| bus_be_o | output | 4 | Byte-lane enables |
| bus_wdata_o | output | 32 | Write data, lane-aligned |
| bus_rdata_i | input | 32 | Read data, full word |
| bus_rdy_i | input | 1 | Access completes in this cycle |
| ack_no | output | 1 | Trigger-accepted strobe, active low |
| end_no | output | 1 | Final-write strobe, active low |

## Verification
The hardest case to reach from the ports is the merging of several triggers that land while a run is already active. A register write takes a full cycle, so the normal write task can never land a second trigger inside a short run. The stimulus therefore holds the write strobe on the trigger register for three consecutive cycles. The first cycle is accepted, and the next two fall into the busy window and must merge into one pending trigger. A similar back-to-back pair, a trigger followed at once by a source address write, shows that configuration writes are dropped during a run. A swept bus latency makes every phase wait a different number of cycles, which tests that request fields stay steady.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int DW = 32;
  localparam int BEW = DW / 8;

  localparam logic [2:0] RA_SRC  = 3'd0;
  localparam logic [2:0] RA_DST  = 3'd1;
  localparam logic [2:0] RA_CNT  = 3'd2;
  localparam logic [2:0] RA_BLK  = 3'd3;
  localparam logic [2:0] RA_CTRL = 3'd4;
  localparam logic [2:0] RA_TRIG = 3'd5;

  localparam logic [1:0] MD_SINGLE = 2'd0;
  localparam logic [1:0] MD_SUCC   = 2'd1;
  localparam logic [1:0] MD_BLOCK  = 2'd2;

  localparam logic [1:0] DIR_UP   = 2'd1;
  localparam logic [1:0] DIR_DOWN = 2'd2;

  typedef struct packed {
    logic       hw_en;
    logic       dst_rld;
    logic       src_rld;
    logic [1:0] dst_dir;
    logic [1:0] src_dir;
    logic [1:0] mode;
    logic [1:0] size;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [BEW-1:0] lane_be(input logic [1:0] sz, input logic [1:0] lane);
    case (sz)
      2'd0:    return 4'b0001 << lane;
      2'd1:    return 4'b0011 << {lane[1], 1'b0};
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  input  logic          step_i,
  input  logic          rld_i,
  input  logic [1:0]    dir_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] cur_o
);
  logic [AW-1:0] init_q, cur_q;
  logic [AW-1:0] delta;

  assign delta = {{(AW-3){1'b0}}, unit_bytes(size_i)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      cur_q  <= '0;
    end else if (ld_i) begin
      init_q <= ld_val_i;
      cur_q  <= ld_val_i;
    end else if (rld_i) begin
      cur_q <= init_q;  // restore wins over the final step
    end else if (step_i) begin
      case (dir_i)
        DIR_UP:   cur_q <= cur_q + delta;
        DIR_DOWN: cur_q <= cur_q - delta;
        default:  cur_q <= cur_q;
      endcase
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  input  logic          hw_req_i,
  input  logic [AW-1:0] src_cur_i,
  input  logic [AW-1:0] dst_cur_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [2:0]    status_i,
  output ctrl_t         ctrl_o,
  output logic [CW-1:0] blk_o,
  output logic          ld_src_o,
  output logic          ld_dst_o,
  output logic          cnt_wr_o,
  output logic          trig_o,
  output logic [DW-1:0] rdata_o
);
  ctrl_t         ctrl_q;
  logic [CW-1:0] blk_q;
  logic          hw_q;
  logic          wr_ok;

  assign wr_ok = we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      blk_q  <= '0;
      hw_q   <= 1'b0;
    end else begin
      hw_q <= hw_req_i;
      if (wr_ok && addr_i == RA_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_ok && addr_i == RA_BLK)  blk_q  <= wdata_i[CW-1:0];
    end
  end

  assign ld_src_o = wr_ok && addr_i == RA_SRC;
  assign ld_dst_o = wr_ok && addr_i == RA_DST;
  assign cnt_wr_o = wr_ok && addr_i == RA_CNT;
  assign trig_o   = (we_i && addr_i == RA_TRIG && wdata_i[0])
                  || (ctrl_q.hw_en && hw_req_i && !hw_q);

  always_comb begin
    case (addr_i)
      RA_SRC:  rdata_o = DW'(src_cur_i);
      RA_DST:  rdata_o = DW'(dst_cur_i);
      RA_CNT:  rdata_o = DW'(cnt_i);
      RA_BLK:  rdata_o = DW'(blk_q);
      RA_CTRL: rdata_o = DW'(ctrl_q);
      RA_TRIG: rdata_o = DW'(status_i);
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign blk_o  = blk_q;
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           trig_i,
  input  ctrl_t          ctrl_i,
  input  logic [CW-1:0]  blk_i,
  input  logic           cnt_wr_i,
  input  logic [CW-1:0]  cnt_val_i,
  input  logic [AW-1:0]  src_addr_i,
  input  logic [AW-1:0]  dst_addr_i,
  input  logic [DW-1:0]  bus_rdata_i,
  input  logic           bus_rdy_i,
  output logic           bus_req_o,
  output logic           bus_we_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [BEW-1:0] bus_be_o,
  output logic [DW-1:0]  bus_wdata_o,
  output logic           step_o,
  output logic           src_rld_o,
  output logic           dst_rld_o,
  output logic           busy_o,
  output logic [2:0]     status_o,
  output logic [CW-1:0]  cnt_o,
  output logic           ack_no,
  output logic           end_no
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_e;

  st_e           st_q;
  logic [CW-1:0] cnt_q, units_q, units_init;
  logic [DW-1:0] hold_q;
  logic          pend_q, done_q, ack_q;
  logic          go, accept, wr_done, last, is_blk, is_succ, runs_restore;

  assign is_succ      = ctrl_i.mode == MD_SUCC;
  assign is_blk       = ctrl_i.mode == MD_BLOCK;
  assign runs_restore = is_succ || is_blk;
  assign go           = trig_i || pend_q;
  assign accept       = st_q == ST_IDLE && !cnt_wr_i && go && cnt_q != '0;
  assign wr_done      = st_q == ST_WR && bus_rdy_i;
  assign last         = units_q == CW'(1);

  always_comb begin
    if (is_succ)     units_init = cnt_q;
    else if (is_blk) units_init = (blk_i == '0) ? CW'(1) : blk_i;
    else             units_init = CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      units_q <= '0;
      hold_q  <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= accept;
      if (st_q != ST_IDLE && trig_i) pend_q <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (cnt_wr_i) begin
            cnt_q  <= cnt_val_i;
            done_q <= 1'b0;
            if (trig_i) pend_q <= 1'b1;
          end else if (go) begin
            pend_q <= 1'b0;  // a trigger with zero count is dropped here
            if (accept) begin
              st_q    <= ST_RD;
              units_q <= units_init;
            end
          end
        end
        ST_RD: begin
          if (bus_rdy_i) begin
            hold_q <= bus_rdata_i >> {src_addr_i[1:0], 3'b000};
            st_q   <= ST_WR;
          end
        end
        ST_WR: begin
          if (bus_rdy_i) begin
            units_q <= units_q - CW'(1);
            if (!is_blk || last) cnt_q <= cnt_q - CW'(1);
            if (last) begin
              st_q <= ST_IDLE;
              if (cnt_q == CW'(1)) done_q <= 1'b1;
            end else begin
              st_q <= ST_RD;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_o   = st_q != ST_IDLE;
  assign bus_we_o    = st_q == ST_WR;
  assign bus_addr_o  = bus_we_o ? dst_addr_i : src_addr_i;
  assign bus_be_o    = lane_be(ctrl_i.size, bus_addr_o[1:0]);
  assign bus_wdata_o = hold_q << {dst_addr_i[1:0], 3'b000};
  assign step_o      = wr_done;
  assign src_rld_o   = wr_done && last && runs_restore && ctrl_i.src_rld;
  assign dst_rld_o   = wr_done && last && runs_restore && ctrl_i.dst_rld;
  assign busy_o      = st_q != ST_IDLE;
  assign status_o    = {pend_q, done_q, busy_o};
  assign cnt_o       = cnt_q;
  assign ack_no      = !ack_q;
  assign end_no      = !(st_q == ST_WR && last);
endmodule

// File: rtl/dma_dual_chan.sv
module dma_dual_chan
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_addr_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic [31:0]   cfg_rdata_o,
  input  logic          hw_req_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [3:0]    bus_be_o,
  output logic [31:0]   bus_wdata_o,
  input  logic [31:0]   bus_rdata_i,
  input  logic          bus_rdy_i,
  output logic          ack_no,
  output logic          end_no
);
  localparam int NSIDE = 2;  // 0 = source, 1 = destination

  ctrl_t         ctrl;
  logic [CW-1:0] blk, cnt;
  logic [2:0]    status;
  logic          busy, cnt_wr, trig, step;
  logic [NSIDE-1:0]         ld, rld;
  logic [NSIDE-1:0][1:0]    dir;
  logic [NSIDE-1:0][AW-1:0] cur;

  assign dir[0] = ctrl.src_dir;
  assign dir[1] = ctrl.dst_dir;

  dma_cfg_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .busy_i    (busy),
    .hw_req_i  (hw_req_i),
    .src_cur_i (cur[0]),
    .dst_cur_i (cur[1]),
    .cnt_i     (cnt),
    .status_i  (status),
    .ctrl_o    (ctrl),
    .blk_o     (blk),
    .ld_src_o  (ld[0]),
    .ld_dst_o  (ld[1]),
    .cnt_wr_o  (cnt_wr),
    .trig_o    (trig),
    .rdata_o   (cfg_rdata_o)
  );

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_addr_unit #(.AW(AW)) u_addr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (ld[g]),
      .ld_val_i (cfg_wdata_i[AW-1:0]),
      .step_i   (step),
      .rld_i    (rld[g]),
      .dir_i    (dir[g]),
      .size_i   (ctrl.size),
      .cur_o    (cur[g])
    );
  end

  dma_xfer_fsm #(.AW(AW), .CW(CW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig),
    .ctrl_i      (ctrl),
    .blk_i       (blk),
    .cnt_wr_i    (cnt_wr),
    .cnt_val_i   (cfg_wdata_i[CW-1:0]),
    .src_addr_i  (cur[0]),
    .dst_addr_i  (cur[1]),
    .bus_rdata_i (bus_rdata_i),
    .bus_rdy_i   (bus_rdy_i),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_be_o    (bus_be_o),
    .bus_wdata_o (bus_wdata_o),
    .step_o      (step),
    .src_rld_o   (rld[0]),
    .dst_rld_o   (rld[1]),
    .busy_o      (busy),
    .status_o    (status),
    .cnt_o       (cnt),
    .ack_no      (ack_no),
    .end_no      (end_no)
  );
endmodule

// File: rtl/dma_dual_chan_sva.sv
module dma_dual_chan_sva #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [3:0]    bus_be_o,
  input logic          bus_rdy_i,
  input logic          ack_no,
  input logic          end_no
);
  a_r14_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_rdy_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_be_o));

  a_r1_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_we_o && bus_rdy_i |=> bus_req_o && bus_we_o);

  a_r2_be_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> ($countones(bus_be_o) == 1 || $countones(bus_be_o) == 2 || $countones(bus_be_o) == 4));

  a_r8_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_no |=> ack_no);

  a_r8_ack_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_no |-> bus_req_o && !bus_we_o);

  a_r8_ack_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !$past(bus_req_o) |-> !ack_no);

  a_r9_end_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_no |-> bus_req_o && bus_we_o);

  a_r9_end_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_no && !bus_rdy_i |=> !end_no);
endmodule

bind dma_dual_chan dma_dual_chan_sva #(.AW(AW)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_o  (bus_req_o),
  .bus_we_o   (bus_we_o),
  .bus_addr_o (bus_addr_o),
  .bus_be_o   (bus_be_o),
  .bus_rdy_i  (bus_rdy_i),
  .ack_no     (ack_no),
  .end_no     (end_no)
);

// File: tb/sim_dma_dual_chan.sv
`timescale 1ns/1ps
module sim_dma_dual_chan;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        hw_req_i = 1'b0;
  logic        bus_req_o, bus_we_o;
  logic [31:0] bus_addr_o;
  logic [3:0]  bus_be_o;
  logic [31:0] bus_wdata_o;
  logic [31:0] bus_rdata_i = '0;
  logic        bus_rdy_i = 1'b0;
  logic        ack_no, end_no;

  dma_dual_chan u0 (.*);

  always #5 clk_i = ~clk_i;

  int nchk = 0, nfail = 0;
  int ack_cnt = 0, end_cnt = 0, rd_cnt = 0, be_err = 0, ord_err = 0, hs_err = 0;
  int wt = 0, cyc = 0;
  int cur_sz = 0;
  bit exp_we = 0, prev_wait = 0;
  logic [31:0] prev_addr = '0;
  logic [7:0] mem [256];
  logic [7:0] exp_m [256];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  // bus responder and strobe monitor, all on the falling edge
  always @(negedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
    if (rst_ni) begin
      if (prev_wait && (!bus_req_o || bus_addr_o != prev_addr)) hs_err++;
      if (!ack_no) ack_cnt++;
      if (bus_rdy_i) begin
        bus_rdy_i = 1'b0;
        wt = $urandom_range(3);
      end else if (bus_req_o) begin
        if (wt == 0) begin
          logic [7:0] a;
          logic [3:0] eb;
          a = bus_addr_o[7:0];
          eb = (cur_sz == 0) ? (4'b0001 << a[1:0]) : (cur_sz == 1) ? (4'b0011 << {a[1], 1'b0}) : 4'b1111;
          if (bus_be_o != eb) be_err++;
          if (bus_we_o != exp_we) ord_err++;
          exp_we = !bus_we_o;
          bus_rdy_i = 1'b1;
          if (bus_we_o) begin
            for (int l = 0; l < 4; l++)
              if (bus_be_o[l]) mem[{a[7:2], 2'(l)}] = bus_wdata_o[8*l +: 8];
            if (!end_no) end_cnt++;
          end else begin
            rd_cnt++;
            bus_rdata_i = {mem[{a[7:2], 2'd3}], mem[{a[7:2], 2'd2}], mem[{a[7:2], 2'd1}], mem[{a[7:2], 2'd0}]};
          end
        end else wt--;
      end
      prev_wait = bus_req_o && !bus_rdy_i;
      prev_addr = bus_addr_o;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    cfg_addr_i = a;
    #1 d = cfg_rdata_o;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    int n = 0;
    do begin
      rd(3'd5, st);
      n++;
    end while ((st[0] || st[2]) && n < 3000);
    repeat (2) @(negedge clk_i);
  endtask

  function automatic logic [31:0] ctrl_w(int sz, int md, int sd, int dd, int srl, int drl, int hw);
    return 32'(sz | (md << 2) | (sd << 4) | (dd << 6) | (srl << 8) | (drl << 9) | (hw << 10));
  endfunction

  function automatic logic [7:0] stepa(logic [7:0] a, int dir, int nb);
    if (dir == 1) return a + 8'(nb);
    if (dir == 2) return a - 8'(nb);
    return a;
  endfunction

  task automatic fill(int k);
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'((i * 29 + k * 13 + 5) & 255);
      exp_m[i] = mem[i];
    end
  endtask

  task automatic sweep_one(int sz, int md, int sd, int dd, int k);
    logic [31:0] v;
    logic [7:0] s0, d0, s, d;
    int nb, ntrig, nunit, srl, drl, a0, e0, mism;
    nb = 1 << sz;
    cur_sz = sz;
    s0 = (sd == 1) ? 8'h10 : 8'h70;
    d0 = (dd == 0) ? 8'hC0 : (dd == 1) ? 8'h90 : 8'hE8;
    srl = k % 2;
    drl = (k / 2) % 2;
    ntrig = (md == 1) ? 1 : 3;
    nunit = (md == 0) ? 1 : (md == 1) ? 3 : 2;
    fill(k);
    wr(3'd4, ctrl_w(sz, md, sd, dd, srl, drl, 0));
    wr(3'd0, 32'(s0));
    wr(3'd1, 32'(d0));
    wr(3'd2, 32'd3);
    wr(3'd3, 32'd2);
    a0 = ack_cnt; e0 = end_cnt;
    s = s0; d = d0;
    for (int t = 0; t < ntrig; t++) begin
      wr(3'd5, 32'd1);
      wait_idle();
      for (int u = 0; u < nunit; u++) begin
        for (int b = 0; b < nb; b++) exp_m[8'(d + 8'(b))] = exp_m[8'(s + 8'(b))];
        s = stepa(s, sd, nb);
        d = stepa(d, dd, nb);
      end
      if (md != 0) begin
        if (srl != 0) s = s0;
        if (drl != 0) d = d0;
      end
    end
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_m[i]) mism++;
    chk(mism == 0, (md == 0) ? "R1 R3 data" : (md == 1) ? "R1 R4 data" : "R1 R5 data", 32'(mism), 0);
    rd(3'd0, v); chk(v == 32'(s), "R6 R7 src addr", v, 32'(s));
    rd(3'd1, v); chk(v == 32'(d), "R6 R7 dst addr", v, 32'(d));
    rd(3'd2, v); chk(v == 0, "R3 R4 R5 count", v, 0);
    rd(3'd5, v); chk(v == 32'd2, "R11 done status", v, 32'd2);
    chk(ack_cnt - a0 == ntrig, "R8 ack pulses", 32'(ack_cnt - a0), 32'(ntrig));
    chk(end_cnt - e0 == ntrig, "R9 end writes", 32'(end_cnt - e0), 32'(ntrig));
    chk(be_err == 0, "R2 byte enables", 32'(be_err), 0);
  endtask

  initial begin
    logic [31:0] v;
    int a0, r0;
    repeat (3) @(negedge clk_i);
    // reset state
    chk(ack_no && end_no && !bus_req_o, "reset strobes", {ack_no, end_no, bus_req_o}, 3'b110);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk(v == 0, "reset regs", v, 0);
    end
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R11: trigger with zero count is dropped
    a0 = ack_cnt; r0 = rd_cnt;
    wr(3'd5, 32'd1);
    repeat (6) @(negedge clk_i);
    chk(ack_cnt == a0 && rd_cnt == r0, "R11 zero count ignored", 32'(rd_cnt - r0), 0);
    rd(3'd5, v); chk(v == 0, "R11 status after drop", v, 0);

    // sweep of sizes, modes and directions
    for (int sz = 0; sz < 3; sz++)
      for (int md = 0; md < 3; md++)
        for (int sd = 1; sd < 3; sd++)
          for (int dd = 0; dd < 3; dd++)
            sweep_one(sz, md, sd, dd, sz * 18 + md * 6 + (sd - 1) * 3 + dd);

    // R11: count write clears done
    wr(3'd2, 32'd3);
    rd(3'd5, v); chk(v == 0, "R11 done cleared by count write", v, 0);

    // R10: three back-to-back triggers, one pending slot
    cur_sz = 2; fill(100);
    wr(3'd4, ctrl_w(2, 0, 1, 1, 0, 0, 0));
    wr(3'd0, 32'h20);
    wr(3'd1, 32'hA0);
    a0 = ack_cnt;
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 3'd5; cfg_wdata_i = 32'd1;
    repeat (3) @(negedge clk_i);
    cfg_we_i = 1'b0;
    wait_idle();
    chk(ack_cnt - a0 == 2, "R10 pending merged", 32'(ack_cnt - a0), 2);
    rd(3'd2, v); chk(v == 1, "R10 count left", v, 1);
    rd(3'd1, v); chk(v == 32'hA8, "R10 dst after two units", v, 32'hA8);

    // R13: address write during a run is ignored
    wr(3'd2, 32'd2);
    wr(3'd0, 32'h30);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 3'd5; cfg_wdata_i = 32'd1;
    @(negedge clk_i);
    cfg_addr_i = 3'd0; cfg_wdata_i = 32'h44;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    wait_idle();
    rd(3'd0, v); chk(v == 32'h34, "R13 busy write ignored", v, 32'h34);
    wr(3'd0, 32'h48);
    rd(3'd0, v); chk(v == 32'h48, "R13 idle write taken", v, 32'h48);

    // R12: hardware trigger edge, enabled then disabled
    wr(3'd4, ctrl_w(2, 0, 1, 1, 0, 0, 1));
    wr(3'd2, 32'd2);
    a0 = ack_cnt;
    @(negedge clk_i); hw_req_i = 1'b1;
    repeat (8) @(negedge clk_i); hw_req_i = 1'b0;
    wait_idle();
    chk(ack_cnt - a0 == 1, "R12 one run per edge", 32'(ack_cnt - a0), 1);
    rd(3'd2, v); chk(v == 1, "R12 count after edge", v, 1);
    wr(3'd4, ctrl_w(2, 0, 1, 1, 0, 0, 0));
    a0 = ack_cnt;
    @(negedge clk_i); hw_req_i = 1'b1;
    repeat (8) @(negedge clk_i); hw_req_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(ack_cnt == a0, "R12 disabled edge ignored", 32'(ack_cnt - a0), 0);
    rd(3'd2, v); chk(v == 1, "R12 count unchanged", v, 1);

    chk(ord_err == 0, "R1 read-write order", 32'(ord_err), 0);
    chk(hs_err == 0, "R14 request held until ready", 32'(hs_err), 0);
    finish_run();
  end
endmodule